// File: doc/BRIEF.md
# Compare-and-Branch-if-Equal Unit

This unit executes one fused compare-and-branch instruction. It compares an 8-bit register with an operand byte. When the two are equal it branches by a signed 8-bit displacement. Otherwise execution falls through to the next instruction. The caller has already fetched the opcode and presents it on `opcode`, together with the accumulator, the 16-bit index register, the stack pointer and the address of the first opcode byte. The unit then reads its own remaining instruction bytes and, for the memory forms, the operand byte through a byte-wide read port. It holds the instruction for a fixed number of cycles that depends on the addressing form.

Six forms exist:
- A against a zero-page byte.
- A against an immediate byte.
- The low index byte against an immediate byte.
- A against the byte at index plus an unsigned 8-bit offset, with index post-increment.
- A against the byte at index, with index post-increment.
- A prefixed form: A against the byte at stack pointer plus an unsigned 8-bit offset.

In the done cycle the unit presents the next PC, a taken flag and, for the two post-increment forms, an index-register write. No condition flag is produced or altered. An opcode outside the six forms raises a one-cycle illegal pulse and nothing else happens.

Top module: `cbeq_unit`

## Requirements
- R1: After reset `busy`, `done`, `illegal`, `mem_rd`, `hx_we` and `taken` are all 0.
- R2: Legal opcodes are 0x0031, 0x0041, 0x0051, 0x0061, 0x0071 and 0x9E61 (upper byte 0x9E is the prefix). Any other value with `start` high while idle makes `illegal` high for exactly the following cycle. In that case `busy`, `done`, `hx_we` and `mem_rd` stay 0.
- R3: The cycle in which `start` is sampled counts as cycle 1. `done` is high in cycle 5 for 0x31, cycle 4 for 0x41 and 0x51, cycle 5 for 0x61, cycle 4 for 0x71, and cycle 6 for 0x9E61.
- R4: Reads are issued in this order, where P is the address of the first opcode byte:
  - 0x31: P+1, {0x00,dd}, P+2.
  - 0x41 and 0x51: P+1, P+2.
  - 0x61: P+1, H:X+ff, P+2.
  - 0x71: H:X, P+1.
  - 0x9E61: P+2, SP+ff, P+3.
  
  Offsets are zero-extended and all address sums wrap at 16 bits.
- R5: The compared register is A, except for 0x51, which compares the low byte of H:X. The immediate byte is the operand for 0x41 and 0x51.
- R6: When register and operand are equal, `taken` is 1 and `next_pc` = P + length + sign-extended last instruction byte, modulo 2^16. The lengths are 3 for 0x31, 0x41, 0x51 and 0x61, 2 for 0x71, and 4 for 0x9E61.
- R7: When they differ, `taken` is 0 and `next_pc` = P + length, modulo 2^16.
- R8: For 0x61 and 0x71, `hx_we` is 1 in the done cycle with `hx_next` = H:X+1 modulo 2^16, whether or not the branch is taken. For the other forms `hx_we` stays 0.
- R9: `start` is ignored while `busy` is 1, and inputs are sampled only when an instruction is accepted.
- R10: `done` is a single-cycle pulse, and `busy` is 0 in the cycle after it.
- R11: `mem_rd` is only high while `busy`, never in the done cycle, and exactly as many reads occur as R4 lists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (accepted when idle) |
| opcode | input | 16 | Prefix byte (0x00 or 0x9E) and opcode byte |
| acc | input | 8 | Accumulator A |
| hx | input | 16 | Index register H:X |
| sp | input | 16 | Stack pointer |
| pc | input | 16 | Address of the first opcode byte |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction; results valid |
| illegal | output | 1 | One-cycle pulse for an unrecognised opcode |
| taken | output | 1 | Branch taken (with `done`) |
| next_pc | output | 16 | Address of the next instruction (with `done`) |
| hx_next | output | 16 | New H:X value |
| hx_we | output | 1 | Write strobe for `hx_next` |

## Verification
The bench targets several corner cases:
- A negative displacement that wraps the PC below zero. A design that zero-extends the offset lands far forward instead.
- An instruction placed at the top of memory, so that its bytes wrap to address 0.
- A post-increment of H:X = 0xFFFF, which must give 0x0000. A carry error shows up here.
- An X-immediate compare where the high index byte equals the immediate but the low byte does not. A design that compares the wrong register or byte branches in that case.
- A prefixed form whose idle fifth cycle separates a correct six-cycle count from an early done.
- A `start` held high with changing inputs throughout an instruction, which exposes any relaunch or late sampling.
- Malformed prefix combinations, which must raise only the illegal pulse.

// File: rtl/cbeq_pkg.sv
package cbeq_pkg;
  localparam int PC_W   = 16;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 3;

  typedef logic [PC_W-1:0]   addr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t PREFIX = 8'h9E;

  typedef enum logic [2:0] {
    M_DIR, M_IMMA, M_IMMX, M_IX1P, M_IXP, M_SP1, M_BAD
  } mode_e;

  typedef enum logic [1:0] {PH_ARG, PH_MEM, PH_REL, PH_WAIT} phase_e;

  function automatic mode_e classify(input logic [2*BYTE_W-1:0] op);
    mode_e r;
    r = M_BAD;
    if (op[2*BYTE_W-1:BYTE_W] == 8'h00) begin
      case (op[BYTE_W-1:0])
        8'h31:   r = M_DIR;
        8'h41:   r = M_IMMA;
        8'h51:   r = M_IMMX;
        8'h61:   r = M_IX1P;
        8'h71:   r = M_IXP;
        default: r = M_BAD;
      endcase
    end else if (op[2*BYTE_W-1:BYTE_W] == PREFIX && op[BYTE_W-1:0] == 8'h61) begin
      r = M_SP1;
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] ins_len(input mode_e m);
    case (m)
      M_IXP:   return 3'd2;
      M_SP1:   return 3'd4;
      M_BAD:   return 3'd1;
      default: return 3'd3;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] ins_cycles(input mode_e m);
    case (m)
      M_DIR, M_IX1P:         return 3'd5;
      M_IMMA, M_IMMX, M_IXP: return 3'd4;
      M_SP1:                 return 3'd6;
      default:               return 3'd1;
    endcase
  endfunction

  function automatic logic post_inc(input mode_e m);
    return (m == M_IX1P) || (m == M_IXP);
  endfunction

  function automatic logic is_imm(input mode_e m);
    return (m == M_IMMA) || (m == M_IMMX);
  endfunction

  function automatic addr_t sext8(input byte_t b);
    return {{(PC_W-BYTE_W){b[BYTE_W-1]}}, b};
  endfunction

  function automatic addr_t zext8(input byte_t b);
    return {{(PC_W-BYTE_W){1'b0}}, b};
  endfunction

  function automatic addr_t branch_target(input addr_t p, input logic [CNT_W-1:0] len,
                                          input byte_t rel, input logic take);
    addr_t fall;
    fall = p + addr_t'(len);
    return take ? fall + sext8(rel) : fall;
  endfunction
endpackage

// File: rtl/cbeq_decode.sv
module cbeq_decode
  import cbeq_pkg::*;
(
  input  logic [2*BYTE_W-1:0] op,
  output mode_e               mode,
  output logic                bad,
  output logic [CNT_W-1:0]    ncyc
);
  always_comb begin
    mode = classify(op);
    bad  = (mode == M_BAD);
    ncyc = ins_cycles(mode);
  end
endmodule

// File: rtl/cbeq_seq.sv
module cbeq_seq
  import cbeq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  mode_e            mode_i,
  input  logic [CNT_W-1:0] ncyc_i,
  input  addr_t            pc_i,
  input  addr_t            hx_i,
  input  addr_t            sp_i,
  input  byte_t            acc_i,
  input  byte_t            mem_rdata,
  output addr_t            mem_addr,
  output logic             mem_rd,
  output logic             busy,
  output logic             last,
  output mode_e            mode_q,
  output addr_t            pc_q,
  output addr_t            hx_q,
  output byte_t            acc_q,
  output byte_t            opnd_q,
  output byte_t            rel_q
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q, ncyc_q;
  addr_t            sp_q;
  byte_t            arg_q;
  logic             reads_done;

  assign reads_done = (phase_q == PH_WAIT);
  assign last       = busy && (cnt_q == ncyc_q);
  assign mem_rd     = busy && !reads_done;

  always_comb begin
    mem_addr = pc_q;
    case (phase_q)
      PH_ARG: mem_addr = pc_q + ((mode_q == M_SP1) ? addr_t'(2) : addr_t'(1));
      PH_MEM: begin
        case (mode_q)
          M_DIR:   mem_addr = zext8(arg_q);
          M_IX1P:  mem_addr = hx_q + zext8(arg_q);
          M_SP1:   mem_addr = sp_q + zext8(arg_q);
          default: mem_addr = hx_q;
        endcase
      end
      PH_REL:  mem_addr = pc_q + addr_t'(ins_len(mode_q)) - addr_t'(1);
      default: mem_addr = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      phase_q <= PH_WAIT;
      cnt_q   <= '0;
      ncyc_q  <= '0;
      mode_q  <= M_BAD;
      pc_q    <= '0;
      hx_q    <= '0;
      sp_q    <= '0;
      acc_q   <= '0;
      arg_q   <= '0;
      opnd_q  <= '0;
      rel_q   <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      cnt_q   <= 3'd2;
      ncyc_q  <= ncyc_i;
      mode_q  <= mode_i;
      pc_q    <= pc_i;
      hx_q    <= hx_i;
      sp_q    <= sp_i;
      acc_q   <= acc_i;
      phase_q <= (mode_i == M_IXP) ? PH_MEM : PH_ARG;
    end else if (busy) begin
      cnt_q <= cnt_q + 3'd1;
      if (last) busy <= 1'b0;
      case (phase_q)
        PH_ARG: begin
          arg_q <= mem_rdata;
          if (is_imm(mode_q)) begin
            opnd_q  <= mem_rdata;
            phase_q <= PH_REL;
          end else begin
            phase_q <= PH_MEM;
          end
        end
        PH_MEM: begin
          opnd_q  <= mem_rdata;
          phase_q <= PH_REL;
        end
        PH_REL: begin
          rel_q   <= mem_rdata;
          phase_q <= PH_WAIT;
        end
        default: phase_q <= PH_WAIT;
      endcase
    end
  end

  // R3: the cycle counter never ends an instruction before its reads are finished
  assert_reads_before_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> reads_done);
  // R10: the done pulse lasts exactly one cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !last && !busy);
  // R11: reads only while an instruction is in progress
  assert_rd_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy && !last);
endmodule

// File: rtl/cbeq_resolve.sv
module cbeq_resolve
  import cbeq_pkg::*;
(
  input  logic  finish,
  input  mode_e mode_q,
  input  addr_t pc_q,
  input  addr_t hx_q,
  input  byte_t acc_q,
  input  byte_t opnd_q,
  input  byte_t rel_q,
  output logic  taken,
  output addr_t next_pc,
  output addr_t hx_next,
  output logic  hx_we
);
  byte_t cmp_reg;
  byte_t diff;
  logic  equal;

  always_comb begin
    cmp_reg = (mode_q == M_IMMX) ? hx_q[BYTE_W-1:0] : acc_q;
    diff    = cmp_reg - opnd_q;
    equal   = (diff == '0);
    taken   = finish && equal;
    next_pc = branch_target(pc_q, ins_len(mode_q), rel_q, equal);
    hx_we   = finish && post_inc(mode_q);
    hx_next = post_inc(mode_q) ? hx_q + addr_t'(1) : hx_q;
  end
endmodule

// File: rtl/cbeq_unit.sv
module cbeq_unit
  import cbeq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] opcode,
  input  logic [7:0]  acc,
  input  logic [15:0] hx,
  input  logic [15:0] sp,
  input  logic [15:0] pc,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic        illegal,
  output logic        taken,
  output logic [15:0] next_pc,
  output logic [15:0] hx_next,
  output logic        hx_we
);
  mode_e            dec_mode, mode_q;
  logic             dec_bad;
  logic [CNT_W-1:0] dec_ncyc;
  logic             accept, launch, reject;
  addr_t            pc_q, hx_q;
  byte_t            acc_q, opnd_q, rel_q;

  cbeq_decode u_decode (
    .op   (opcode),
    .mode (dec_mode),
    .bad  (dec_bad),
    .ncyc (dec_ncyc)
  );

  assign accept = start && !busy;
  assign launch = accept && !dec_bad;
  assign reject = accept && dec_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) illegal <= 1'b0;
    else        illegal <= reject;
  end

  cbeq_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .mode_i    (dec_mode),
    .ncyc_i    (dec_ncyc),
    .pc_i      (pc),
    .hx_i      (hx),
    .sp_i      (sp),
    .acc_i     (acc),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .busy      (busy),
    .last      (done),
    .mode_q    (mode_q),
    .pc_q      (pc_q),
    .hx_q      (hx_q),
    .acc_q     (acc_q),
    .opnd_q    (opnd_q),
    .rel_q     (rel_q)
  );

  cbeq_resolve u_resolve (
    .finish  (done),
    .mode_q  (mode_q),
    .pc_q    (pc_q),
    .hx_q    (hx_q),
    .acc_q   (acc_q),
    .opnd_q  (opnd_q),
    .rel_q   (rel_q),
    .taken   (taken),
    .next_pc (next_pc),
    .hx_next (hx_next),
    .hx_we   (hx_we)
  );

  // R2: an illegal opcode never starts an instruction
  assert_illegal_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !busy && !mem_rd && !done);
  // R8: the index write happens only in the done cycle
  assert_hxwe_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hx_we |-> done);
  // R9: a start during an instruction cannot end or restart it early
  assert_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  // R9: an instruction only begins when start was sampled
  assert_begin_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/cbeq_unit_bench.sv
`timescale 1ns/1ps
module cbeq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] opcode = 16'h0000;
  logic [7:0]  acc = 8'h00;
  logic [15:0] hx = 16'h0000, sp = 16'h0000, pc = 16'h0000;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata;
  logic        busy, done, illegal, taken, hx_we;
  logic [15:0] next_pc, hx_next;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [15:0] ov_a [8];
  logic [7:0]  ov_d [8];
  int          ov_n = 0;

  always #4 clk = ~clk;

  always_comb begin
    mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'hA5;
    for (int i = 0; i < 8; i++)
      if (i < ov_n && ov_a[i] == mem_addr) mem_rdata = ov_d[i];
  end

  cbeq_unit u_cbeq_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .acc(acc),
    .hx(hx), .sp(sp), .pc(pc), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .illegal(illegal),
    .taken(taken), .next_pc(next_pc), .hx_next(hx_next), .hx_we(hx_we)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d);
    ov_a[ov_n] = a;
    ov_d[ov_n] = d;
    ov_n++;
  endtask

  task automatic run_cbeq(input string tag, input logic [15:0] op, input logic [7:0] a,
                          input logic [15:0] x, input logic [15:0] s, input logic [15:0] p,
                          input logic [7:0] arg, input logic [7:0] opv, input logic [7:0] rel,
                          input bit hold);
    int len, ncyc, nexp, k, nrd, disp;
    logic [15:0] ea [3];
    logic [15:0] got [8];
    logic [15:0] argaddr, reladdr, oaddr, exp_pc;
    logic [7:0]  cmp, operand;
    bit imm, pinc, eq;
    imm  = (op == 16'h0041) || (op == 16'h0051);
    pinc = (op == 16'h0061) || (op == 16'h0071);
    case (op)
      16'h0031: begin len = 3; ncyc = 5; oaddr = {8'h00, arg}; end
      16'h0041: begin len = 3; ncyc = 4; oaddr = 16'h0; end
      16'h0051: begin len = 3; ncyc = 4; oaddr = 16'h0; end
      16'h0061: begin len = 3; ncyc = 5; oaddr = x + {8'h00, arg}; end
      16'h0071: begin len = 2; ncyc = 4; oaddr = x; end
      default:  begin len = 4; ncyc = 6; oaddr = s + {8'h00, arg}; end
    endcase
    argaddr = p + ((op == 16'h9E61) ? 16'd2 : 16'd1);
    reladdr = p + 16'(len - 1);
    ov_n = 0;
    if (op != 16'h0071) put(argaddr, arg);
    put(reladdr, rel);
    if (!imm) put(oaddr, opv);
    if (op == 16'h0071) begin nexp = 2; ea[0] = x; ea[1] = reladdr; ea[2] = 16'h0; end
    else if (imm) begin nexp = 2; ea[0] = argaddr; ea[1] = reladdr; ea[2] = 16'h0; end
    else begin nexp = 3; ea[0] = argaddr; ea[1] = oaddr; ea[2] = reladdr; end
    cmp     = (op == 16'h0051) ? x[7:0] : a;
    operand = imm ? arg : opv;
    eq      = (cmp == operand);
    disp    = (rel > 8'd127) ? int'(rel) - 256 : int'(rel);
    exp_pc  = eq ? 16'(int'(p) + len + disp) : 16'(int'(p) + len);

    opcode = op; acc = a; hx = x; sp = s; pc = p; start = 1'b1;
    @(negedge clk);
    if (!hold) start = 1'b0;
    k = 2; nrd = 0;
    forever begin
      if (mem_rd && nrd < 8) begin got[nrd] = mem_addr; nrd++; end
      if (done || k > 12) break;
      if (hold) begin opcode = 16'h0041; pc = 16'hBEEF; acc = ~a; hx = ~x; sp = ~s; end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R3", {tag, " done seen"}, int'(done), 1);
    chk(k == ncyc, "R3", {tag, " done cycle"}, k, ncyc);
    chk(mem_rd == 1'b0, "R11", {tag, " no read in done cycle"}, int'(mem_rd), 0);
    chk(nrd == nexp, "R11", {tag, " read count"}, nrd, nexp);
    for (int i = 0; i < 3; i++)
      if (i < nexp && i < nrd)
        chk(got[i] == ea[i], "R4", {tag, " read address"}, int'(got[i]), int'(ea[i]));
    chk(taken == eq, eq ? "R6" : "R7", {tag, " taken"}, int'(taken), int'(eq));
    chk(next_pc == exp_pc, eq ? "R6" : "R7", {tag, " next_pc"}, int'(next_pc), int'(exp_pc));
    chk(hx_we == pinc, "R8", {tag, " hx_we"}, int'(hx_we), int'(pinc));
    if (pinc)
      chk(hx_next == 16'(x + 16'd1), "R8", {tag, " hx_next"}, int'(hx_next), int'(16'(x + 16'd1)));
    @(negedge clk);
    chk(!done && !busy, "R10", {tag, " done single pulse"}, int'({done, busy}), 0);
  endtask

  task automatic run_illegal(input logic [15:0] op);
    opcode = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(illegal == 1'b1, "R2", "illegal raised", int'(illegal), 1);
    chk(!busy && !mem_rd, "R2", "illegal idle", int'({busy, mem_rd}), 0);
    @(negedge clk);
    chk(!illegal && !busy && !done && !hx_we && !mem_rd, "R2", "illegal one cycle only",
        int'({illegal, busy, done, hx_we, mem_rd}), 0);
    @(negedge clk);
    chk(!busy && !done, "R2", "illegal no later activity", int'({busy, done}), 0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!busy && !done && !illegal && !mem_rd && !hx_we && !taken, "R1", "reset state",
        int'({busy, done, illegal, mem_rd, hx_we, taken}), 0);
    @(negedge clk);
    run_cbeq("dir eq R6",      16'h0031, 8'h3C, 16'h0000, 16'h0000, 16'h2000, 8'h40, 8'h3C, 8'h10, 0);
    run_cbeq("dir ne R7",      16'h0031, 8'h3C, 16'h0000, 16'h0000, 16'h2100, 8'h41, 8'h3D, 8'h10, 0);
    run_cbeq("imma wrap R6",   16'h0041, 8'h77, 16'h0000, 16'h0000, 16'h0002, 8'h77, 8'h00, 8'h80, 0);
    run_cbeq("immx eq R5",     16'h0051, 8'h11, 16'hAB55, 16'h0000, 16'h3000, 8'h55, 8'h00, 8'h05, 0);
    run_cbeq("immx ne R5",     16'h0051, 8'h55, 16'h5511, 16'h0000, 16'h3000, 8'h55, 8'h00, 8'h05, 0);
    run_cbeq("ix1+ eq R8",     16'h0061, 8'h9A, 16'h12F0, 16'h0000, 16'h4000, 8'h20, 8'h9A, 8'hFE, 0);
    run_cbeq("ix+ wrap R8",    16'h0071, 8'h02, 16'hFFFF, 16'h0000, 16'h5000, 8'h00, 8'h01, 8'h33, 0);
    run_cbeq("ix+ eq R6",      16'h0071, 8'hC0, 16'h0800, 16'h0000, 16'h5100, 8'h00, 8'hC0, 8'h7F, 0);
    run_cbeq("sp1 eq R3",      16'h9E61, 8'h44, 16'h0000, 16'h00F0, 16'h6000, 8'h1A, 8'h44, 8'h20, 0);
    run_cbeq("sp1 ne R7",      16'h9E61, 8'h44, 16'h0000, 16'hFFF0, 16'h6100, 8'h20, 8'h45, 8'h20, 0);
    run_cbeq("pc top R4",      16'h0031, 8'h01, 16'h0000, 16'h0000, 16'hFFFE, 8'h50, 8'h02, 8'h04, 0);
    run_cbeq("start held R9",  16'h0031, 8'h3C, 16'h1234, 16'h0000, 16'h2000, 8'h40, 8'h3C, 8'h10, 1);
    run_cbeq("ix1 held R9",    16'h0061, 8'h21, 16'h0100, 16'h0000, 16'h7000, 8'h05, 8'h21, 8'h08, 1);
    run_illegal(16'h0021);
    run_illegal(16'h9E62);
    run_illegal(16'h0131);
    run_illegal(16'h9E31);
    report();
  end
endmodule